// File: doc/BRIEF.md
# Resynchronizing Bus Clock Divider

This block derives a local bus-phase clock, one twelfth of a stable master clock (8 MHz from 96 MHz), for an accelerator that sits on a slower host bus. The block does not lock the divider to the host bus clock all the time. The divider runs free, and the block corrects its phase only when the accelerator's bus logic starts a host-bus transfer. The host clock is jittery and not trusted as a timing reference, so between transfers the two clocks may drift apart.

A rising edge on the request input stops the divider. The block then waits for a falling edge of the host clock. When that edge arrives, it reloads the divider so that the local clock falls on the same master cycle. It then raises an acknowledge, and holds it until the request drops. If no host falling edge arrives within a bounded window, the block gives up: it flags a timeout and restarts the divider from the start of its high phase.

The controller has three states:
- `ST_FREE`: the divider runs free.
- `ST_HALT`: the divider is stopped and the block waits for a host edge.
- `ST_ALIGNED`: the divider runs and the acknowledge is high.

The transitions are:
- **start**: `ST_FREE`→`ST_HALT`, on a rising edge of the request.
- **lock**: `ST_HALT`→`ST_ALIGNED`, when a host falling edge is detected.
- **expire**: `ST_HALT`→`ST_FREE`, when the wait window runs out.
- **release**: `ST_ALIGNED`→`ST_FREE`, when the request goes low.

Top module: `bus_clk_resync`

## Requirements
- R1: During and straight after reset, the phase count is 0: `phase_o`=1, `rise_en_o`=1, `aligned_o`=0 and `timeout_o`=0.
- R2: While running, the count steps 0..11 and wraps. `phase_o` is 1 for counts 0–5 and 0 for counts 6–11. `rise_en_o` is 1 only at count 0 while the divider is not stopped.
- R3: Host clock falling edges while no transfer is starting or waiting leave the divider phase unchanged.
- R4: A 0→1 change on `req_i` causes the count to advance once more and then hold. While held, `phase_o` is frozen and `rise_en_o` is 0.
- R5: The host clock passes through a two-stage synchronizer. A host clock that falls before master edge k causes the count to load 6 at edge k+2 (`phase_o` goes 0). `aligned_o` rises at that same edge.
- R6: `aligned_o` stays 1 while `req_i` is held. It drops one cycle after `req_i` goes low. The divider keeps running across this change.
- R7: If no host falling edge is detected in 24 stopped cycles, `timeout_o` becomes 1 and the count restarts at 0 and runs. A `req_i` that is still high does not stop the divider again.
- R8: A host falling edge detected in the last (24th) stopped cycle wins over the timeout. An edge detected one cycle later arrives after the timeout and is ignored.
- R9: `timeout_o` holds until the next 0→1 change on `req_i`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (96 MHz nominal) |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_clk_i | input | 1 | Asynchronous host bus clock |
| req_i | input | 1 | Host-access request from the bus logic; a rising edge starts alignment |
| phase_o | output | 1 | Local divided clock level (1 = high half) |
| rise_en_o | output | 1 | One-cycle enable at the start of each local period |
| aligned_o | output | 1 | Alignment acknowledge, held until request drops |
| timeout_o | output | 1 | No host edge seen in the wait window |

## Verification
The lock and expire transitions can both fall in the same master cycle. This happens when the synchronized host falling edge shows up in the final cycle of the wait window. The bench provokes this by dropping the host clock exactly 22 cycles after the request edge. It then checks that the acknowledge rises with the count at 6 and that no timeout is reported. It repeats the run with the host edge one cycle later and expects the timeout, with the divider restarted at count 0 and the late edge having no effect.

// File: rtl/resync_pkg.sv
`timescale 1ns/1ps
package resync_pkg;
    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_HALT    = 2'd1,
        ST_ALIGNED = 2'd2
    } rs_state_e;
endpackage

// File: rtl/host_edge_sync.sv
`timescale 1ns/1ps
module host_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              synced;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign synced = chain_q[STAGES-1];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= synced;
    end

    assign fall_o = prev_q & ~synced;

    // R5: a detected edge never repeats on consecutive cycles
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/phase_div.sv
`timescale 1ns/1ps
module phase_div #(
    parameter int DIV = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    hold_i,
    input  logic                    load_i,
    input  logic                    clear_i,
    output logic [$clog2(DIV)-1:0]  cnt_o,
    output logic                    phase_o,
    output logic                    rise_en_o
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (load_i)   cnt_q <= CW'(HALF);
        else if (hold_i)   cnt_q <= cnt_q;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o     = cnt_q;
    assign phase_o   = (cnt_q < CW'(HALF));
    assign rise_en_o = (cnt_q == '0) && !hold_i;

    // R4: a held divider keeps its count
    a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !load_i && !clear_i) |=> $stable(cnt_q));
    // R5: a load places the local falling edge
    a_r5_load_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !clear_i) |=> (cnt_q == CW'(HALF)) && !phase_o);
    // R2: the count wraps after its last value
    a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !load_i && !clear_i && cnt_q == CW'(DIV - 1)) |=> cnt_q == '0);
    // R2: the count stays inside the period
    a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CW'(DIV));
endmodule

// File: rtl/resync_fsm.sv
`timescale 1ns/1ps
module resync_fsm
    import resync_pkg::*;
#(
    parameter int TIMEOUT = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic fall_i,
    output logic hold_o,
    output logic load_o,
    output logic clear_o,
    output logic aligned_o,
    output logic timeout_o
);
    localparam int WCW = $clog2(TIMEOUT + 1);

    rs_state_e      state_q, state_d;
    logic           req_q;
    logic [WCW-1:0] wait_q;
    logic           start;
    logic           expired;

    assign start   = req_i & ~req_q;
    assign expired = (state_q == ST_HALT) && (wait_q == WCW'(TIMEOUT - 1)) && !fall_i;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_FREE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:    if (start)       state_d = ST_HALT;
            ST_HALT:    if (fall_i)      state_d = ST_ALIGNED;
                        else if (expired) state_d = ST_FREE;
            ST_ALIGNED: if (!req_i)      state_d = ST_FREE;
            default:                     state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q     <= 1'b0;
            wait_q    <= '0;
            timeout_o <= 1'b0;
        end else begin
            req_q <= req_i;
            if (state_q == ST_FREE && start)  wait_q <= '0;
            else if (state_q == ST_HALT)      wait_q <= wait_q + 1'b1;
            if (state_q == ST_FREE && start)  timeout_o <= 1'b0;
            else if (expired)                 timeout_o <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        hold_o    = 1'b0;
        load_o    = 1'b0;
        clear_o   = 1'b0;
        aligned_o = 1'b0;
        unique case (state_q)
            ST_FREE:    ;
            ST_HALT: begin
                load_o  = fall_i;
                clear_o = expired;
                hold_o  = !fall_i && !expired;
            end
            ST_ALIGNED: aligned_o = 1'b1;
            default:    ;
        endcase
    end

    // R7: the wait never outlasts its window
    a_r7_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT) |-> (wait_q < WCW'(TIMEOUT)));
    // R5: a lock raises the acknowledge next cycle
    a_r5_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |=> aligned_o && !timeout_o);
    // R6: acknowledge persists while the request is held
    a_r6_hold_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aligned_o && req_i) |=> aligned_o);
    // R7: expiry raises the flag and leaves the wait
    a_r7_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_o |=> timeout_o && (state_q == ST_FREE));
    // R8: lock and expiry never act together
    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({hold_o, load_o, clear_o}) <= 1);
endmodule

// File: rtl/bus_clk_resync.sv
`timescale 1ns/1ps
module bus_clk_resync #(
    parameter int DIV         = 12,
    parameter int TIMEOUT     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic host_clk_i,
    input  logic req_i,
    output logic phase_o,
    output logic rise_en_o,
    output logic aligned_o,
    output logic timeout_o
);
    localparam int CW = $clog2(DIV);

    logic          host_fall;
    logic          hold, load, clear;
    logic [CW-1:0] cnt;

    host_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (host_clk_i),
        .fall_o  (host_fall)
    );

    resync_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .fall_i    (host_fall),
        .hold_o    (hold),
        .load_o    (load),
        .clear_o   (clear),
        .aligned_o (aligned_o),
        .timeout_o (timeout_o)
    );

    phase_div #(.DIV(DIV)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (hold),
        .load_i    (load),
        .clear_i   (clear),
        .cnt_o     (cnt),
        .phase_o   (phase_o),
        .rise_en_o (rise_en_o)
    );

    // R7: an expiry restarts the local period
    a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> (cnt == '0) && phase_o);
endmodule

// File: tb/bus_clk_resync_tb.sv
`timescale 1ns/1ps
module bus_clk_resync_tb;
    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic host_clk = 1'b1;
    logic req = 1'b0;
    logic phase, rise_en, aligned, timeout;

    int checks = 0;
    int errors = 0;
    int ncnt = 0;
    int ref_n = 0;
    int ref_c = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        string tag;
        logic  ph, re, al, to;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    bus_clk_resync u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .host_clk_i (host_clk),
        .req_i      (req),
        .phase_o    (phase),
        .rise_en_o  (rise_en),
        .aligned_o  (aligned),
        .timeout_o  (timeout)
    );

    always @(posedge clk) ncnt <= ncnt + 1;

    // monitor: compare every expected item due at this negedge
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == ncnt) begin
                checks++;
                if ({phase, rise_en, aligned, timeout} !==
                    {q[i].ph, q[i].re, q[i].al, q[i].to}) begin
                    errors++;
                    $display("FAIL %s at %0d: ph/re/al/to actual %b%b%b%b expected %b%b%b%b",
                             q[i].tag, ncnt, phase, rise_en, aligned, timeout,
                             q[i].ph, q[i].re, q[i].al, q[i].to);
                end
                q.delete(i);
            end
        end
    end

    function automatic int cnt_at(int n);
        return (ref_c + n - ref_n) % 12;
    endfunction

    task automatic push(int at, string tag, logic ph, logic re, logic al, logic to);
        exp_t e;
        e.at = at; e.tag = tag; e.ph = ph; e.re = re; e.al = al; e.to = to;
        q.push_back(e);
    endtask

    task automatic push_run(int at, string tag, logic al, logic to);
        int c;
        c = cnt_at(at);
        push(at, tag, c < 6, c == 0, al, to);
    endtask

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int t, c;
        step(2);
        t = ncnt;
        push(t + 1, "R1 in reset", 1, 1, 0, 0);
        step(3);
        rst_ni = 1'b1;
        ref_n = ncnt; ref_c = 0;
        t = ncnt;
        push(t, "R1 after release", 1, 1, 0, 0);
        // R2 free run pattern
        push_run(t + 3,  "R2 high half", 0, 0);
        push_run(t + 6,  "R2 low half", 0, 0);
        push_run(t + 11, "R2 last count", 0, 0);
        push_run(t + 12, "R2 wrap", 0, 0);
        push_run(t + 18, "R2 second low", 0, 0);
        step(20);
        // R3 host edges while free are ignored
        host_clk = 1'b0;
        t = ncnt;
        push_run(t + 3, "R3 no shift", 0, 0);
        push_run(t + 4, "R3 no shift", 0, 0);
        step(6);
        host_clk = 1'b1;
        t = ncnt;
        push_run(t + 4, "R3 no shift", 0, 0);
        step(14);
        // R4/R5/R6 alignment
        req = 1'b1;
        t = ncnt;
        c = cnt_at(t + 1);
        push(t + 1, "R4 halted", c < 6, 0, 0, 0);
        push(t + 3, "R4 halted", c < 6, 0, 0, 0);
        step(4);
        host_clk = 1'b0;
        t = ncnt;
        push(t + 2, "R4 still halted", c < 6, 0, 0, 0);
        push(t + 3, "R5 aligned load", 0, 0, 1, 0);
        ref_n = t + 3; ref_c = 6;
        push_run(t + 9,  "R6 running aligned", 1, 0);
        push_run(t + 12, "R6 held ack", 1, 0);
        step(8);
        host_clk = 1'b1;
        step(4);
        req = 1'b0;
        t = ncnt;
        push_run(t, "R6 before release", 1, 0);
        push_run(t + 1, "R6 released", 0, 0);
        push_run(t + 4, "R6 keeps running", 0, 0);
        step(10);
        // R7 timeout with host idle
        req = 1'b1;
        t = ncnt;
        c = cnt_at(t + 1);
        push(t + 1,  "R7 halted", c < 6, 0, 0, 0);
        push(t + 24, "R7 last wait", c < 6, 0, 0, 0);
        push(t + 25, "R7 timeout", 1, 1, 0, 1);
        ref_n = t + 25; ref_c = 0;
        push_run(t + 30, "R7 no rehalt", 0, 1);
        push_run(t + 31, "R7 no rehalt", 0, 1);
        step(34);
        push_run(ncnt + 1, "R9 flag held", 0, 1);
        step(2);
        req = 1'b0;
        step(2);
        // R8 edge in last window cycle, also R9 clear
        req = 1'b1;
        t = ncnt;
        c = cnt_at(t + 1);
        push(t + 1,  "R9 cleared on start", c < 6, 0, 0, 0);
        push(t + 24, "R8 waiting", c < 6, 0, 0, 0);
        push(t + 25, "R8 late lock wins", 0, 0, 1, 0);
        step(22);
        host_clk = 1'b0;
        step(3);
        ref_n = ncnt; ref_c = 6;
        push_run(ncnt + 2, "R8 aligned running", 1, 0);
        step(4);
        host_clk = 1'b1;
        req = 1'b0;
        step(8);
        // R8 edge one cycle too late
        req = 1'b1;
        t = ncnt;
        push(t + 25, "R8 timeout first", 1, 1, 0, 1);
        ref_n = t + 25; ref_c = 0;
        push_run(t + 26, "R8 late edge ignored", 0, 1);
        push_run(t + 28, "R8 late edge ignored", 0, 1);
        step(23);
        host_clk = 1'b0;
        step(8);
        host_clk = 1'b1;
        req = 1'b0;
        step(4);
        if (q.size() != 0) begin
            errors += q.size();
            $display("FAIL scoreboard: actual %0d unchecked expected 0", q.size());
        end
        finish_run();
    end
endmodule